// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between a clocked host and an external static RAM that has no clock. The host hands over one request at a time (address, a write flag and, for writes, the data). The block then plays out the matching strobe pattern on the memory side: active-low chip select, output enable and write enable, an address bus, and separate outbound and inbound data paths. While a pattern is in progress the host sees the block as busy. For a read, the sampled word comes back through a registered result that is flagged for a single cycle.

Every analogue timing limit of the memory is given as a parameter in whole clock cycles. The block turns them into phase lengths. A write has three phases: address setup with chip select low, the write pulse, and an address and data hold. A read has two: an access window with chip select and output enable low, and a turnaround with all strobes high, which lets the memory release its output. The write pulse is stretched when chip select would otherwise not have been low long enough, or when data setup would not be met. The read window is as long as the slowest of the address, chip-select and output-enable access paths.

Top module: `sram_seq`

## Requirements
- R1: After a synchronous active-low reset, including one taken in the middle of a sequence, chip select, output enable and write enable are all high, `req_ready` is 1 and `rd_valid` is 0 on the first cycle after the reset edge.
- R2: On a write, chip select is low and the address is unchanged for at least `T_AS` cycles before write enable falls.
- R3: Write enable stays low for exactly max(`T_WP`, `T_CSW`−`T_AS`, `T_DS`−`T_AS`) cycles. When it rises, chip select has been low for at least `T_CSW` cycles and the write data has been unchanged for at least `T_DS` cycles.
- R4: Address and write data do not change while write enable is low. They, and a low chip select, are held for max(`T_AH`, `T_DH`) cycles counted from the cycle in which write enable returns high. Chip select stays low for the whole write sequence.
- R5: On a read, chip select and output enable are low together for max(`T_AA`, `T_ACS`, `T_OE`) cycles. The inbound data is sampled at the end of the last of those cycles.
- R6: After each read, `rd_valid` is 1 for exactly one cycle, with `rd_data` holding the sampled word. A write never raises `rd_valid`.
- R7: Each read ends with `T_OZ` cycles with chip select and output enable high before the block returns to idle.
- R8: `req_ready` is 1 only in idle. A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is then 0 for exactly `T_AS`+pulse+hold cycles for a write, or access+`T_OZ` cycles for a read, and is 1 for at least one cycle between sequences.
- R9: Address and write data are captured at acceptance. Changes on `req_addr` or `req_wdata` during a sequence do not reach the memory pins.
- R10: Write enable and output enable are never low in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Request write data |
| req_ready | output | 1 | Idle, can accept a request |
| rd_data | output | DATA_W | Last word read |
| rd_valid | output | 1 | One-cycle flag for new `rd_data` |
| sram_cs_n | output | 1 | Memory chip select, active low |
| sram_oe_n | output | 1 | Memory output enable, active low |
| sram_we_n | output | 1 | Memory write enable, active low |
| sram_addr | output | ADDR_W | Memory address |
| sram_wdata | output | DATA_W | Data driven to the memory |
| sram_rdata | input | DATA_W | Data returned by the memory |

## Verification
The hardest case to reach is a read that samples one cycle too early. A correct memory still drives a stable bus at that point, so nothing visible goes wrong. The bench therefore uses a cycle-counting memory model that returns the bitwise inverse of the stored word until chip select, output enable and the address have each been steady for their own access time. An early capture then shows up as a data mismatch. The same model measures setup, pulse, chip-select and hold intervals around every write-enable edge. Directed tests hold `req_valid` high across sequences, change the request fields while busy, and reset in the middle of a write pulse.

// File: rtl/sram_seq_pkg.sv
// Package: shared sequencer state type and a small helper for phase lengths.
// Assumes all timing parameters are whole cycles of at least 1.
package sram_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_WSETUP  = 3'd1,
        ST_WPULSE  = 3'd2,
        ST_WHOLD   = 3'd3,
        ST_RACCESS = 3'd4,
        ST_RTURN   = 3'd5
    } seq_state_t;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_seq_timer.sv
// Phase timer: loaded with (length-1) on entry to a phase and counted down.
// zero marks the last cycle of the phase. Assumes the load value fits CW bits.
module sram_seq_timer #(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          zero
);
    logic [CW-1:0] cnt;

    // Load on phase entry, otherwise count down to zero and stay there.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/sram_seq_ctrl.sv
// Sequencer control: walks the write (setup, pulse, hold) and read
// (access, turnaround) phases and decodes the memory strobes from state.
// Assumes every phase length parameter is at least 1.
module sram_seq_ctrl
    import sram_seq_pkg::*;
#(
    parameter int CW         = 3,
    parameter int SETUP_LEN  = 1,
    parameter int PULSE_LEN  = 1,
    parameter int HOLD_LEN   = 1,
    parameter int ACCESS_LEN = 1,
    parameter int TURN_LEN   = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic          tmr_zero,
    output logic          tmr_load,
    output logic [CW-1:0] tmr_val,
    output logic          accept,
    output logic          capture,
    output logic          ready,
    output logic          cs_n,
    output logic          oe_n,
    output logic          we_n
);
    localparam logic [CW-1:0] V_SETUP  = CW'(SETUP_LEN - 1);
    localparam logic [CW-1:0] V_PULSE  = CW'(PULSE_LEN - 1);
    localparam logic [CW-1:0] V_HOLD   = CW'(HOLD_LEN - 1);
    localparam logic [CW-1:0] V_ACCESS = CW'(ACCESS_LEN - 1);
    localparam logic [CW-1:0] V_TURN   = CW'(TURN_LEN - 1);

    seq_state_t state, state_nxt;

    // Next-state, timer load and capture strobe for the current phase.
    always_comb begin
        state_nxt = state;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        capture   = 1'b0;
        case (state)
            ST_IDLE: if (req_valid) begin
                tmr_load = 1'b1;
                if (req_write) begin
                    state_nxt = ST_WSETUP;
                    tmr_val   = V_SETUP;
                end else begin
                    state_nxt = ST_RACCESS;
                    tmr_val   = V_ACCESS;
                end
            end
            ST_WSETUP: if (tmr_zero) begin
                state_nxt = ST_WPULSE;
                tmr_load  = 1'b1;
                tmr_val   = V_PULSE;
            end
            ST_WPULSE: if (tmr_zero) begin
                state_nxt = ST_WHOLD;
                tmr_load  = 1'b1;
                tmr_val   = V_HOLD;
            end
            ST_WHOLD: if (tmr_zero) state_nxt = ST_IDLE;
            ST_RACCESS: if (tmr_zero) begin
                capture   = 1'b1;
                state_nxt = ST_RTURN;
                tmr_load  = 1'b1;
                tmr_val   = V_TURN;
            end
            ST_RTURN: if (tmr_zero) state_nxt = ST_IDLE;
            default: state_nxt = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // Strobe decode: one state register feeds each strobe.
    assign ready  = (state == ST_IDLE);
    assign accept = ready && req_valid;
    assign cs_n   = !(state == ST_WSETUP || state == ST_WPULSE ||
                      state == ST_WHOLD  || state == ST_RACCESS);
    assign we_n   = (state != ST_WPULSE);
    assign oe_n   = (state != ST_RACCESS);

    p_we_oe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(!we_n && !oe_n));

    p_busy_after_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !ready);

    p_we_needs_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> !cs_n);
endmodule

// File: rtl/sram_seq_rdcap.sv
// Read capture: registers the memory's inbound data on the capture strobe
// and flags it for one cycle. Assumes capture is a single-cycle pulse.
module sram_seq_rdcap #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dvalid
);
    // Sample inbound data and raise the one-cycle valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout   <= '0;
            dvalid <= 1'b0;
        end else begin
            dvalid <= capture;
            if (capture) dout <= din;
        end
    end

    p_rdv_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dvalid |=> !dvalid);
endmodule

// File: rtl/sram_seq.sv
// Asynchronous SRAM access sequencer top. Holds the accepted address and
// write data on the memory pins for the whole sequence and derives every
// phase length from the cycle-count timing parameters (each at least 1).
module sram_seq
    import sram_seq_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int T_AS   = 2,
    parameter int T_WP   = 3,
    parameter int T_CSW  = 6,
    parameter int T_DS   = 2,
    parameter int T_AH   = 2,
    parameter int T_DH   = 1,
    parameter int T_AA   = 3,
    parameter int T_ACS  = 4,
    parameter int T_OE   = 2,
    parameter int T_OZ   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              sram_cs_n,
    output logic              sram_oe_n,
    output logic              sram_we_n,
    output logic [ADDR_W-1:0] sram_addr,
    output logic [DATA_W-1:0] sram_wdata,
    input  logic [DATA_W-1:0] sram_rdata
);
    localparam int PULSE_LEN  = imax(T_WP, imax(T_CSW - T_AS, T_DS - T_AS));
    localparam int HOLD_LEN   = imax(T_AH, T_DH);
    localparam int ACCESS_LEN = imax(T_AA, imax(T_ACS, T_OE));
    localparam int MAX_LEN    = imax(imax(T_AS, PULSE_LEN),
                                     imax(HOLD_LEN, imax(ACCESS_LEN, T_OZ)));
    localparam int CW         = (MAX_LEN < 2) ? 1 : $clog2(MAX_LEN);

    logic          tmr_load, tmr_zero, accept, capture;
    logic [CW-1:0] tmr_val;

    sram_seq_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    sram_seq_ctrl #(
        .CW         (CW),
        .SETUP_LEN  (T_AS),
        .PULSE_LEN  (PULSE_LEN),
        .HOLD_LEN   (HOLD_LEN),
        .ACCESS_LEN (ACCESS_LEN),
        .TURN_LEN   (T_OZ)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .tmr_zero  (tmr_zero),
        .tmr_load  (tmr_load),
        .tmr_val   (tmr_val),
        .accept    (accept),
        .capture   (capture),
        .ready     (req_ready),
        .cs_n      (sram_cs_n),
        .oe_n      (sram_oe_n),
        .we_n      (sram_we_n)
    );

    sram_seq_rdcap #(.DATA_W(DATA_W)) u_rdcap (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .din     (sram_rdata),
        .dout    (rd_data),
        .dvalid  (rd_valid)
    );

    // Capture the request fields at acceptance; they then drive the pins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sram_addr  <= '0;
            sram_wdata <= '0;
        end else if (accept) begin
            sram_addr  <= req_addr;
            sram_wdata <= req_wdata;
        end
    end

    p_addr_stable_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_we_n && !$past(sram_we_n)) |-> $stable(sram_addr));

    p_cs_before_we_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sram_we_n) |-> ($past(sram_cs_n) == 1'b0));
endmodule

// File: tb/tb_sram_seq.sv
// Bench: cycle-counting SRAM model with timing checks, a vector table of
// writes and reads, then directed tests for reset, back-to-back and latching.
module tb_sram_seq;
    localparam int AW = 8, DW = 8;
    localparam int T_AS = 2, T_WP = 3, T_CSW = 6, T_DS = 2, T_AH = 2, T_DH = 1;
    localparam int T_AA = 3, T_ACS = 4, T_OE = 2, T_OZ = 2;

    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
    localparam int PULSE   = mx(T_WP, mx(T_CSW - T_AS, T_DS - T_AS));
    localparam int HOLD    = mx(T_AH, T_DH);
    localparam int ACCESS  = mx(T_AA, mx(T_ACS, T_OE));
    localparam int WR_BUSY = T_AS + PULSE + HOLD;
    localparam int RD_BUSY = ACCESS + T_OZ;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic req_ready, rd_valid, sram_cs_n, sram_oe_n, sram_we_n;
    logic [DW-1:0] rd_data, sram_wdata;
    logic [DW-1:0] sram_rdata = '0;
    logic [AW-1:0] sram_addr;

    sram_seq #(.ADDR_W(AW), .DATA_W(DW), .T_AS(T_AS), .T_WP(T_WP),
               .T_CSW(T_CSW), .T_DS(T_DS), .T_AH(T_AH), .T_DH(T_DH),
               .T_AA(T_AA), .T_ACS(T_ACS), .T_OE(T_OE), .T_OZ(T_OZ)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rd_data(rd_data), .rd_valid(rd_valid), .sram_cs_n(sram_cs_n),
        .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n), .sram_addr(sram_addr),
        .sram_wdata(sram_wdata), .sram_rdata(sram_rdata)
    );

    always #4 clk = ~clk;

    int checks = 0, errors = 0;
    bit done = 1'b0;
    bit quiet = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Behavioural memory and its expected-content shadow.
    logic [DW-1:0] mem  [0:255];
    logic [DW-1:0] shad [0:255];
    initial for (int i = 0; i < 256; i++) begin
        mem[i]  = DW'(i * 7 + 3);
        shad[i] = DW'(i * 7 + 3);
    end

    // Memory model: counts steady cycles at each mid-cycle sample.
    logic [AW-1:0] last_addr = '0;
    logic [DW-1:0] last_wd = '0;
    logic last_we = 1'b1;
    int a_cnt = 0, d_cnt = 0, cs_cnt = 0, oe_cnt = 0, we_cnt = 0, hold_cnt = 0;
    bit in_hold = 1'b0;
    always @(negedge clk) begin
        int a_pr, d_pr;
        bit same_a, same_d;
        same_a = (sram_addr == last_addr);
        same_d = (sram_wdata == last_wd);
        a_pr = same_a ? a_cnt : 0;
        d_pr = same_d ? d_cnt : 0;
        if (rst_n && !quiet) begin
            if (!sram_we_n && !sram_oe_n) check(0, "R10 we/oe both low", 1, 0);
            if (!sram_we_n && last_we) begin
                check(a_pr >= T_AS, "R2 addr setup", a_pr, T_AS);
                check(!sram_cs_n, "R2 cs low at we fall", sram_cs_n, 0);
            end else if (!sram_we_n && !last_we) begin
                if (!same_a || !same_d) check(0, "R4 change during pulse", 1, 0);
            end
            if (sram_we_n && !last_we) begin
                check(we_cnt == PULSE, "R3 pulse width", we_cnt, PULSE);
                check(cs_cnt >= T_CSW, "R3 cs before we rise", cs_cnt, T_CSW);
                check(d_pr >= T_DS, "R3 data setup", d_pr, T_DS);
                mem[last_addr] = last_wd;
                in_hold = 1'b1;
                hold_cnt = 1;
                if (!same_a || !same_d || sram_cs_n) check(0, "R4 hold at rise", 1, 0);
            end else if (in_hold) begin
                if (hold_cnt < HOLD) begin
                    check(same_a && same_d && !sram_cs_n, "R4 hold", hold_cnt, HOLD);
                    hold_cnt++;
                end else in_hold = 1'b0;
            end
        end
        a_cnt  = a_pr + 1;
        d_cnt  = d_pr + 1;
        cs_cnt = sram_cs_n ? 0 : cs_cnt + 1;
        oe_cnt = sram_oe_n ? 0 : oe_cnt + 1;
        we_cnt = sram_we_n ? 0 : we_cnt + 1;
        last_addr = sram_addr;
        last_wd   = sram_wdata;
        last_we   = sram_we_n;
        if (!sram_cs_n && !sram_oe_n && cs_cnt >= T_ACS && a_cnt >= T_AA && oe_cnt >= T_OE)
            sram_rdata = mem[sram_addr];
        else
            sram_rdata = ~mem[sram_addr];
    end

    // One request; returns busy length, rd_valid count, read word, cs-high cycles.
    task automatic do_req(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                          output int busy, output int nv, output logic [DW-1:0] rd,
                          output int turn, output int bad);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_addr = ~a; req_wdata = ~d;
        busy = 0; nv = 0; rd = '0; turn = 0; bad = 0;
        while (!req_ready && busy < 100) begin
            busy++;
            if (sram_addr != a || (w && sram_wdata != d)) bad++;
            if (sram_cs_n) turn++;
            if (rd_valid) begin nv++; rd = rd_data; end
            @(negedge clk);
        end
        if (rd_valid) nv++;
    endtask

    localparam logic [16:0] VEC [0:9] = '{
        {1'b1, 8'h10, 8'h3C}, {1'b1, 8'h11, 8'hC3}, {1'b0, 8'h10, 8'h00},
        {1'b0, 8'h11, 8'h00}, {1'b0, 8'h42, 8'h00}, {1'b1, 8'h42, 8'hFF},
        {1'b0, 8'h42, 8'h00}, {1'b1, 8'h00, 8'h00}, {1'b0, 8'h00, 8'h00},
        {1'b0, 8'hFF, 8'h00}
    };

    initial begin
        repeat (100000) @(posedge clk);
        check(0, "watchdog", 0, 1);
        report();
    end

    initial begin
        int busy, nv, turn, bad, lo;
        logic [DW-1:0] rd;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(sram_cs_n && sram_oe_n && sram_we_n, "R1 strobes high in reset",
              {sram_cs_n, sram_oe_n, sram_we_n}, 7);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready && !rd_valid, "R1 ready after reset", {req_ready, rd_valid}, 2);

        for (int i = 0; i < 10; i++) begin
            bit w;
            logic [AW-1:0] a;
            logic [DW-1:0] d;
            w = VEC[i][16]; a = VEC[i][15:8]; d = VEC[i][7:0];
            do_req(w, a, d, busy, nv, rd, turn, bad);
            check(bad == 0, "R9 pins hold accepted fields", bad, 0);
            if (w) begin
                shad[a] = d;
                check(busy == WR_BUSY, "R8 write busy length", busy, WR_BUSY);
                check(nv == 0, "R6 no rd_valid on write", nv, 0);
                check(turn == 0, "R4 cs low through write", turn, 0);
            end else begin
                check(busy == RD_BUSY, "R8 read busy length", busy, RD_BUSY);
                check(nv == 1, "R6 single rd_valid", nv, 1);
                check(rd == shad[a], "R5 read data", rd, shad[a]);
                check(turn == T_OZ, "R7 turnaround cycles", turn, T_OZ);
            end
        end

        // R8: request held high across sequences: one idle cycle between.
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 8'h11;
        @(negedge clk);
        lo = 0;
        while (!req_ready && lo < 100) begin lo++; @(negedge clk); end
        check(lo == RD_BUSY, "R8 first held sequence", lo, RD_BUSY);
        @(negedge clk);
        check(!req_ready, "R8 re-accept after one idle cycle", req_ready, 0);
        req_valid = 1'b0;
        lo = 1;
        @(negedge clk);
        while (!req_ready && lo < 100) begin lo++; @(negedge clk); end
        check(lo == RD_BUSY, "R8 second held sequence", lo, RD_BUSY);

        // R1: reset in the middle of a write pulse.
        quiet = 1'b1;
        req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h77; req_wdata = 8'h5A;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (T_AS) @(negedge clk);
        check(!sram_we_n, "R3 pulse reached before reset", sram_we_n, 0);
        rst_n = 1'b0;
        @(negedge clk);
        check(sram_cs_n && sram_oe_n && sram_we_n && req_ready && !rd_valid,
              "R1 mid-sequence reset", {sram_cs_n, sram_oe_n, sram_we_n, req_ready, rd_valid}, 30);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        quiet = 1'b0;
        if (mem[8'h77] != shad[8'h77]) shad[8'h77] = mem[8'h77];

        // R5/R6: read after the aborted write still sees memory contents.
        do_req(1'b0, 8'h10, 8'h00, busy, nv, rd, turn, bad);
        check(rd == shad[8'h10] && nv == 1, "R5 read after reset", rd, shad[8'h10]);

        report();
    end
endmodule